// File: doc/BRIEF.md
# Auxiliary Debug Port Access Controller

This block sits behind a chip-level JTAG TAP and controls entry to a bank of debug registers. It follows the TAP state that the chip controller reports on each TCK cycle and keeps its own instruction shift register. It takes part only once two conditions hold. First, the compliance enable `jcomp` is high. Second, the chip controller has passed ownership of the TAP to this auxiliary controller (`aux_grant`). After that, a dedicated enable instruction must be loaded before any register can be reached.

The enable instruction starts a three-state access machine: idle, register select and data access. In register select, a DR scan chooses a 7-bit register address and a direction. The next DR scan, in data access, either reads that register out through TDO or writes a new value into it. The machine then returns to register select, ready for the next access. There is no identification instruction. The device identity is read from address 0 like any other register.

The register contents live outside this block. The block only presents the address, one-cycle read and write strobes, and the write data, and it takes the read data back in.

Top module: `adp_ctrl`

## Requirements
- R1: While `por_n` is low, or in any cycle after `jcomp` was sampled low, the access machine is idle and all shift state is zero. In that state `tdo` is 0 and neither strobe pulses.
- R2: The controller acts on the TAP only while `jcomp` and `aux_grant` are both high. With `aux_grant` low, TAP activity leaves its state unchanged and `tdo` reads 0.
- R3: The following `tap_state` codes are used: test-logic-reset 4'hF, run-test/idle 4'hC, capture-DR 4'h6, shift-DR 4'h2, update-DR 4'h5, capture-IR 4'hE, shift-IR 4'hA and update-IR 4'hD.
  - Capture-IR loads the instruction shifter with ...01, which shifts out LSB first.
  - Update-IR with the enable opcode (default 4'hC) moves the machine to register select.
  - Update-IR with any other opcode moves it to idle.
- R4: In idle, the data path is a 1-bit bypass stage. It captures 0 and delays TDI by one shift.
- R5: In register select, the DR chain is 8 bits, shifted LSB first. Bits 6:0 hold the address and bit 7 is the direction (1 = write).
  - Capture-DR loads the current selection.
  - Update-DR latches the shifted value and moves the machine to data access.
- R6: In data access with a read selected, Capture-DR loads the register value into a 32-bit chain that shifts out LSB first. `reg_rd` pulses for that one cycle when the address is external (1 to 15).
- R7: In data access with a write selected, Capture-DR loads zero. At Update-DR, `reg_wr` pulses for one cycle with `reg_wdata` equal to the 32 bits shifted in and `reg_addr` equal to the selected address.
- R8: Update-DR in data access returns the machine to register select.
- R9: Test-logic-reset returns the access machine to idle.
- R10: Address 0 reads the device identity (default 32'h0F5E_A011). Writes to it have no effect and no strobe.
- R11: Addresses above 15 read as zero, ignore writes and never pulse a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| jcomp | input | 1 | Compliance enable; low clears the controller |
| aux_grant | input | 1 | Chip TAP has handed control to this controller |
| tap_state | input | 4 | Current TAP controller state code |
| tdi | input | 1 | Serial test data in |
| reg_rdata | input | 32 | Read data of the selected external register |
| reg_addr | output | 7 | Selected register address |
| reg_rd | output | 1 | Read strobe, one cycle at Capture-DR |
| reg_wr | output | 1 | Write strobe, one cycle at Update-DR |
| reg_wdata | output | 32 | Write data shifted in |
| tdo | output | 1 | Serial test data out |

## Verification
The assertions assume that `tap_state` holds one code per TCK cycle. They also assume that each capture and update state lasts a single cycle, as a real TAP produces them. The bench drives `tap_state` and `tdi` only at the falling edge and walks short but ordered paths. Each path is capture, shifts, update, then run-test/idle, with the exit and pause states omitted, because the controller gives them no meaning. `reg_rdata` is modelled as a pure function of `reg_addr`, so it is valid in the capture cycle that `reg_rd` marks.

// File: rtl/adp_pkg.sv
package adp_pkg;
   typedef enum logic [3:0] {
      TS_SHIFT_DR   = 4'h2,
      TS_UPDATE_DR  = 4'h5,
      TS_CAPTURE_DR = 4'h6,
      TS_SHIFT_IR   = 4'hA,
      TS_RUN_IDLE   = 4'hC,
      TS_UPDATE_IR  = 4'hD,
      TS_CAPTURE_IR = 4'hE,
      TS_RESET      = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      AS_IDLE   = 2'd0,
      AS_SELECT = 2'd1,
      AS_DATA   = 2'd2
   } acc_state_e;
endpackage

// File: rtl/adp_ir.sv
module adp_ir
   import adp_pkg::*;
#(
   parameter int IR_W      = 4,
   parameter int ENABLE_OP = 12
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            clr,
   input  logic            en,
   input  logic [3:0]      tap_state,
   input  logic            tdi,
   output logic            ir_lsb,
   output logic            load_enable,
   output logic            load_other
);
   localparam logic [IR_W-1:0] OP_CODE  = IR_W'(ENABLE_OP);
   localparam logic [IR_W-1:0] CAP_CODE = IR_W'(1);

   logic [IR_W-1:0] ir_sr;
   logic            upd;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         ir_sr <= '0;
      else if (clr)
         ir_sr <= '0;
      else if (en) begin
         if (tap_state == TS_CAPTURE_IR)
            ir_sr <= CAP_CODE;
         else if (tap_state == TS_SHIFT_IR)
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   assign upd         = en && (tap_state == TS_UPDATE_IR);
   assign load_enable = upd && (ir_sr == OP_CODE);
   assign load_other  = upd && (ir_sr != OP_CODE);
   assign ir_lsb      = ir_sr[0];
endmodule

// File: rtl/adp_fsm.sv
module adp_fsm
   import adp_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       clr,
   input  logic       en,
   input  logic [3:0] tap_state,
   input  logic       load_enable,
   input  logic       load_other,
   output acc_state_e state
);
   acc_state_e nxt;

   always_comb begin
      nxt = state;
      if (tap_state == TS_RESET)
         nxt = AS_IDLE;
      else if (load_enable)
         nxt = AS_SELECT;
      else if (load_other)
         nxt = AS_IDLE;
      else if (tap_state == TS_UPDATE_DR) begin
         case (state)
            AS_SELECT: nxt = AS_DATA;
            AS_DATA:   nxt = AS_SELECT;
            default:   nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         state <= AS_IDLE;
      else if (clr)
         state <= AS_IDLE;
      else if (en)
         state <= nxt;
   end
endmodule

// File: rtl/adp_dr.sv
module adp_dr
   import adp_pkg::*;
#(
   parameter int                ADDR_W    = 7,
   parameter int                DATA_W    = 32,
   parameter int                NUM_EXT   = 15,
   parameter bit                ID_EN     = 1'b1,
   parameter logic [DATA_W-1:0] DEVICE_ID = 32'h0F5E_A011
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr,
   input  logic              en,
   input  logic [3:0]        tap_state,
   input  logic              tdi,
   input  acc_state_e        state,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rw_q,
   output logic              ext_hit,
   output logic              dr_lsb,
   output logic [DATA_W-1:0] dat_sr
);
   localparam int                SEL_W    = ADDR_W + 1;
   localparam logic [ADDR_W-1:0] EXT_LAST = ADDR_W'(NUM_EXT);

   logic [SEL_W-1:0]  sel_sr;
   logic              byp;
   logic              id_hit;
   logic [DATA_W-1:0] id_value;
   logic [DATA_W-1:0] rd_value;

   generate
      if (ID_EN) begin : g_id
         assign id_hit   = (addr_q == '0);
         assign id_value = DEVICE_ID;
      end else begin : g_no_id
         assign id_hit   = 1'b0;
         assign id_value = '0;
      end
   endgenerate

   assign ext_hit  = (addr_q != '0) && (addr_q <= EXT_LAST);
   assign rd_value = id_hit ? id_value : (ext_hit ? reg_rdata : '0);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sel_sr <= '0;
         dat_sr <= '0;
         byp    <= 1'b0;
         addr_q <= '0;
         rw_q   <= 1'b0;
      end else if (clr) begin
         sel_sr <= '0;
         dat_sr <= '0;
         byp    <= 1'b0;
         addr_q <= '0;
         rw_q   <= 1'b0;
      end else if (en) begin
         case (state)
            AS_IDLE: begin
               if (tap_state == TS_CAPTURE_DR)
                  byp <= 1'b0;
               else if (tap_state == TS_SHIFT_DR)
                  byp <= tdi;
            end
            AS_SELECT: begin
               if (tap_state == TS_CAPTURE_DR)
                  sel_sr <= {rw_q, addr_q};
               else if (tap_state == TS_SHIFT_DR)
                  sel_sr <= {tdi, sel_sr[SEL_W-1:1]};
               else if (tap_state == TS_UPDATE_DR) begin
                  rw_q   <= sel_sr[SEL_W-1];
                  addr_q <= sel_sr[ADDR_W-1:0];
               end
            end
            AS_DATA: begin
               if (tap_state == TS_CAPTURE_DR)
                  dat_sr <= rw_q ? '0 : rd_value;
               else if (tap_state == TS_SHIFT_DR)
                  dat_sr <= {tdi, dat_sr[DATA_W-1:1]};
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (state)
         AS_SELECT: dr_lsb = sel_sr[0];
         AS_DATA:   dr_lsb = dat_sr[0];
         default:   dr_lsb = byp;
      endcase
   end
endmodule

// File: rtl/adp_ctrl.sv
module adp_ctrl
   import adp_pkg::*;
#(
   parameter int                IR_W      = 4,
   parameter int                ENABLE_OP = 12,
   parameter int                ADDR_W    = 7,
   parameter int                DATA_W    = 32,
   parameter int                NUM_EXT   = 15,
   parameter bit                ID_EN     = 1'b1,
   parameter logic [DATA_W-1:0] DEVICE_ID = 32'h0F5E_A011
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              jcomp,
   input  logic              aux_grant,
   input  logic [3:0]        tap_state,
   input  logic              tdi,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              tdo
);
   generate
      if (IR_W < 2) begin : g_bad_ir
         $error("adp_ctrl: IR_W must be at least 2");
      end
      if (ENABLE_OP < 0 || ENABLE_OP >= (1 << IR_W)) begin : g_bad_op
         $error("adp_ctrl: ENABLE_OP does not fit IR_W");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_w
         $error("adp_ctrl: ADDR_W or DATA_W too small");
      end
      if (NUM_EXT < 0 || NUM_EXT >= (1 << ADDR_W)) begin : g_bad_ext
         $error("adp_ctrl: NUM_EXT does not fit the address space");
      end
   endgenerate

   logic       en;
   logic       clr;
   logic       ir_lsb;
   logic       load_enable;
   logic       load_other;
   logic       rw_q;
   logic       ext_hit;
   logic       dr_lsb;
   acc_state_e acc_q;

   assign en  = jcomp && aux_grant;
   assign clr = !jcomp;

   adp_ir #(.IR_W(IR_W), .ENABLE_OP(ENABLE_OP)) ir_i (
      .clk(clk), .por_n(por_n), .clr(clr), .en(en),
      .tap_state(tap_state), .tdi(tdi), .ir_lsb(ir_lsb),
      .load_enable(load_enable), .load_other(load_other)
   );

   adp_fsm fsm_i (
      .clk(clk), .por_n(por_n), .clr(clr), .en(en),
      .tap_state(tap_state), .load_enable(load_enable),
      .load_other(load_other), .state(acc_q)
   );

   adp_dr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EXT(NUM_EXT),
      .ID_EN(ID_EN), .DEVICE_ID(DEVICE_ID)
   ) dr_i (
      .clk(clk), .por_n(por_n), .clr(clr), .en(en),
      .tap_state(tap_state), .tdi(tdi), .state(acc_q),
      .reg_rdata(reg_rdata), .addr_q(reg_addr), .rw_q(rw_q),
      .ext_hit(ext_hit), .dr_lsb(dr_lsb), .dat_sr(reg_wdata)
   );

   assign reg_rd = en && (acc_q == AS_DATA) && (tap_state == TS_CAPTURE_DR)
                   && !rw_q && ext_hit;
   assign reg_wr = en && (acc_q == AS_DATA) && (tap_state == TS_UPDATE_DR)
                   && rw_q && ext_hit;
   assign tdo    = en && ((tap_state == TS_SHIFT_IR) ? ir_lsb : dr_lsb);
endmodule

// File: rtl/adp_ctrl_chk.sv
module adp_ctrl_chk
   import adp_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int NUM_EXT = 15
) (
   input logic              clk,
   input logic              por_n,
   input logic              jcomp,
   input logic              aux_grant,
   input logic [3:0]        tap_state,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input acc_state_e        acc_state
);
   localparam logic [ADDR_W-1:0] EXT_LAST = ADDR_W'(NUM_EXT);

   // R1
   jcomp_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      !jcomp |=> (acc_state == AS_IDLE));

   // R2
   no_grant_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (jcomp && !aux_grant) |=> $stable(acc_state));

   // R6
   rd_at_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
      reg_rd |-> (tap_state == TS_CAPTURE_DR));

   // R7
   wr_at_update_chk: assert property (@(posedge clk) disable iff (!por_n)
      reg_wr |-> (tap_state == TS_UPDATE_DR));

   // R8
   data_to_select_chk: assert property (@(posedge clk) disable iff (!por_n)
      (jcomp && aux_grant && acc_state == AS_DATA && tap_state == TS_UPDATE_DR)
      |=> (acc_state == AS_SELECT));

   // R9
   tlr_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
      (jcomp && aux_grant && tap_state == TS_RESET) |=> (acc_state == AS_IDLE));

   // R11
   strobe_in_range_chk: assert property (@(posedge clk) disable iff (!por_n)
      (reg_rd || reg_wr) |-> (reg_addr != '0 && reg_addr <= EXT_LAST));
endmodule

bind adp_ctrl adp_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_EXT(NUM_EXT)) chk_i (
   .clk(clk), .por_n(por_n), .jcomp(jcomp), .aux_grant(aux_grant),
   .tap_state(tap_state), .reg_rd(reg_rd), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .acc_state(acc_q)
);

// File: tb/adp_ctrl_tb_top.sv
`timescale 1ns/1ps
module adp_ctrl_tb_top;
   localparam logic [3:0]  S_TLR = 4'hF, S_RTI = 4'hC, S_CDR = 4'h6, S_SDR = 4'h2,
                           S_UDR = 4'h5, S_CIR = 4'hE, S_SIR = 4'hA, S_UIR = 4'hD;
   localparam logic [3:0]  OP_EN = 4'hC;
   localparam logic [31:0] DEV_ID = 32'h0F5E_A011;
   localparam int          NVEC = 9;
   // bit 39 = write, 38:32 = address, 31:0 = write data
   localparam logic [39:0] VEC [NVEC] = '{
      {1'b0, 7'd3,   32'h0},
      {1'b1, 7'd5,   32'hDEAD_BEEF},
      {1'b0, 7'd0,   32'h0},
      {1'b1, 7'd0,   32'h1234_5678},
      {1'b0, 7'd0,   32'h0},
      {1'b0, 7'd15,  32'h0},
      {1'b0, 7'd16,  32'h0},
      {1'b1, 7'd100, 32'hCAFE_F00D},
      {1'b0, 7'd127, 32'h0}
   };

   logic        clk = 1'b0;
   logic        por_n, jcomp, aux_grant, tdi;
   logic [3:0]  tap_state;
   logic [31:0] reg_rdata, reg_wdata;
   logic [6:0]  reg_addr;
   logic        reg_rd, reg_wr, tdo;

   int checks = 0, failures = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [6:0]  last_wa;
   logic [31:0] last_wd;

   always #2.5 clk = ~clk;

   assign reg_rdata = {16'hC0DE, 9'd0, reg_addr};

   adp_ctrl dut_i (
      .clk(clk), .por_n(por_n), .jcomp(jcomp), .aux_grant(aux_grant),
      .tap_state(tap_state), .tdi(tdi), .reg_rdata(reg_rdata),
      .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .tdo(tdo)
   );

   always @(posedge clk) begin
      if (reg_wr) begin
         wr_cnt  = wr_cnt + 1;
         last_wa = reg_addr;
         last_wd = reg_wdata;
      end
      if (reg_rd) rd_cnt = rd_cnt + 1;
   end

   function automatic logic [31:0] exp_read(input logic [6:0] a);
      if (a == 7'd0) return DEV_ID;
      if (a <= 7'd15) return {16'hC0DE, 9'd0, a};
      return 32'h0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] st, input logic d, output logic o);
      @(negedge clk);
      tap_state = st;
      tdi = d;
      #1 o = tdo;
      @(posedge clk);
   endtask

   task automatic scan_ir(input logic [3:0] op, output logic [3:0] dout);
      logic o;
      step(S_CIR, 1'b0, o);
      for (int i = 0; i < 4; i++) begin
         step(S_SIR, op[i], o);
         dout[i] = o;
      end
      step(S_UIR, 1'b0, o);
      step(S_RTI, 1'b0, o);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      logic o;
      dout = '0;
      step(S_CDR, 1'b0, o);
      for (int i = 0; i < n; i++) begin
         step(S_SDR, din[i], o);
         dout[i] = o;
      end
      step(S_UDR, 1'b0, o);
      step(S_RTI, 1'b0, o);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [3:0]  iro;
      logic [31:0] o, prev_sel;
      int          w0, r0;
      logic        dummy;
      por_n = 1'b0; jcomp = 1'b0; aux_grant = 1'b0; tap_state = S_RTI; tdi = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 tdo in reset", {31'd0, tdo}, 32'd0);
      chk("R1 strobes in reset", {30'd0, reg_rd, reg_wr}, 32'd0);
      por_n = 1'b1;
      jcomp = 1'b1; aux_grant = 1'b1;
      step(S_RTI, 1'b0, dummy);

      // R4: idle bypass before enable instruction
      scan_dr(8, 32'hA5, o);
      chk("R4 bypass in idle", o, 32'h4A);

      // R3: enable instruction, IR capture pattern
      scan_ir(OP_EN, iro);
      chk("R3 IR capture shifts out 01", {30'd0, iro[1:0]}, 32'h1);

      // vector table: select scan then data scan
      prev_sel = 32'h0;
      for (int v = 0; v < NVEC; v++) begin
         logic        rw;
         logic [6:0]  a;
         logic [31:0] d;
         logic        ext;
         rw = VEC[v][39]; a = VEC[v][38:32]; d = VEC[v][31:0];
         ext = (a != 7'd0) && (a <= 7'd15);
         scan_dr(8, {24'd0, rw, a}, o);
         // R5 and R8: select chain captures the previous selection
         chk("R5/R8 select capture", o, prev_sel);
         prev_sel = {24'd0, rw, a};
         w0 = wr_cnt; r0 = rd_cnt;
         scan_dr(32, d, o);
         if (!rw) begin
            // R6 R10 R11: read value
            chk("R6/R10/R11 read data", o, exp_read(a));
            chk("R6/R11 read strobe count", rd_cnt - r0, ext ? 32'd1 : 32'd0);
         end else begin
            chk("R7 write captures zero", o, 32'h0);
            // R7 R10 R11: write strobe only for external addresses
            chk("R7/R10/R11 write strobe count", wr_cnt - w0, ext ? 32'd1 : 32'd0);
            if (ext) begin
               chk("R7 write data", last_wd, d);
               chk("R7 write address", {25'd0, last_wa}, {25'd0, a});
            end
         end
      end

      // R9: test-logic-reset returns to idle
      step(S_TLR, 1'b0, dummy);
      step(S_RTI, 1'b0, dummy);
      scan_dr(8, 32'h3C, o);
      chk("R9 idle after TLR", o, 32'h78);

      // R3: other opcode returns to idle
      scan_ir(OP_EN, iro);
      scan_ir(4'h3, iro);
      scan_dr(8, 32'hFF, o);
      chk("R3 other opcode to idle", o, 32'hFE);

      // R2: no grant, activity ignored
      aux_grant = 1'b0;
      scan_ir(OP_EN, iro);
      chk("R2 tdo low without grant", {28'd0, iro}, 32'd0);
      aux_grant = 1'b1;
      scan_dr(8, 32'h81, o);
      chk("R2 enable ignored without grant", o, 32'h02);

      // R1: jcomp drop clears from data access
      scan_ir(OP_EN, iro);
      scan_dr(8, {24'd0, 1'b1, 7'd5}, o);
      w0 = wr_cnt;
      @(negedge clk); jcomp = 1'b0;
      @(negedge clk); jcomp = 1'b1;
      scan_dr(8, 32'h11, o);
      chk("R1 idle after jcomp low", o, 32'h22);
      chk("R1 no write after jcomp low", wr_cnt - w0, 32'd0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule